// File: doc/BRIEF.md
# JTAG Test Port with Core Reset Register

This block is the test access port of a small microcontroller core. A standard sixteen-state TAP controller, clocked by TCK and steered by TMS, chooses between a 4-bit instruction register and three data registers placed between TDI and TDO. The three data registers are a one-bit bypass stage, a boundary-scan chain over a small set of digital I/O pins, and a one-bit register that holds the core in reset. Every register shifts its least significant bit first.

The boundary-scan chain gives each pin four cells: pull-up disable, output enable, output data and input data. When the external-test instruction is active, the pads are driven from the chain's update latch and the core sees the latched input cell. Under any other instruction, the pads follow the core. The reset register has no update latch. A 1 shifted into it raises the core reset request on the same TCK edge. When the bit returns to 0, the request stays high for a time-out counted in core clocks. The length of that time-out is chosen by a 2-bit input, and the time-out starts again if the bit is set before it runs out.

Top module: `jtag_rstscan_top`

## Requirements
- R1: An active-low `trst_n`, or a TCK edge taken in Test-Logic-Reset, loads the bypass instruction. `trst_n` also clears the reset bit and the time-out counter, so `core_rst_req` falls at once. `tdo_en` is low in every state except Shift-IR and Shift-DR.
- R2: Five TCK cycles with TMS high bring the controller to Test-Logic-Reset from any state.
- R3: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 4'b0001, so the first four bits seen on TDO are 1, 0, 0, 0.
- R4: The opcodes are 4'h0 (external test), 4'h2 (sample/preload), 4'hC (reset register) and 4'hF (bypass). Each of the other twelve opcodes, including the one a high-impedance instruction would occupy, selects the 1-bit bypass stage. That stage captures 0 and delays TDI by one bit.
- R5: The boundary chain is 4×N_PINS bits long and shifts LSB first. Pin i occupies bits 4i (pull-up disable), 4i+1 (output enable), 4i+2 (output data) and 4i+3 (input data). Capture-DR loads the three core-side drive values and the pad input. Under sample/preload the pads keep following the core.
- R6: Under external test, the pads take the update-latch values from the TCK edge that leaves Update-IR, and `core_in` takes the input-data cell. Changes on the core side do not reach the pads. The update latch changes only at Update-DR.
- R7: With the reset register selected, each Shift-DR edge loads TDI into the reset bit. `core_rst_req` rises on the same TCK edge that loads a 1 and stays high while the bit holds 1.
- R8: Capture-DR leaves the reset bit unchanged, so the first bit shifted out is its current value.
- R9: After the edge that clears the bit, `core_rst_req` falls at core clock edge SYNC_STAGES+len. The length len is 16, 256 or 4096 for `tmo_sel` 0, 1 or 2, and 4096 for `tmo_sel` 3.
- R10: Setting the bit again while the time-out runs restarts the time-out in full from the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Test data out, changes on falling TCK |
| tdo_en | output | 1 | High while a shift state drives TDO |
| core_clk | input | 1 | Core clock for the reset time-out |
| tmo_sel | input | 2 | Time-out length select |
| core_rst_req | output | 1 | Reset request to the core |
| core_pud | input | N_PINS | Core pull-up disable per pin |
| core_oe | input | N_PINS | Core output enable per pin |
| core_out | input | N_PINS | Core output data per pin |
| pad_in | input | N_PINS | Pad input level per pin |
| pad_pud | output | N_PINS | Pull-up disable to the pads |
| pad_oe | output | N_PINS | Output enable to the pads |
| pad_out | output | N_PINS | Output data to the pads |
| core_in | output | N_PINS | Input data seen by the core |

## Verification
TDO changes on the falling edge that follows the rising edge which entered or advanced a shift state. The bench therefore reads TDO half a cycle after each rising edge, before it drives the TMS and TDI values for the next rising edge. Pad and `core_in` changes caused by a new instruction appear after the rising edge that leaves Update-IR. The bench inspects them at the next falling edge. `core_rst_req` rises at the very edge that shifts in a 1, and the bench samples it at the falling edge just after that edge. For the time-out, TCK and the core clock run in phase in the bench. It counts the falling edges after the clearing edge and expects the request to read low first at index SYNC_STAGES+len.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_st_e;

   typedef enum logic [1:0] {
      PATH_BYP = 2'd0,
      PATH_BSC = 2'd1,
      PATH_RST = 2'd2
   } dr_path_e;

   localparam int CELLS_PER_PIN = 4;
   localparam int CELL_PUD      = 0;
   localparam int CELL_OE       = 1;
   localparam int CELL_OUT      = 2;
   localparam int CELL_IN       = 3;

   function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
      tap_st_e n;
      case (s)
         TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
         default:   n = TS_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtp_tap_fsm.sv
module jtp_tap_fsm
   import jtp_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   tap_st_e st_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st_q <= TS_RESET;
      else         st_q <= tap_next(st_q, tms);
   end

   assign st = st_q;

endmodule

// File: rtl/jtp_instr_reg.sv
module jtp_instr_reg
   import jtp_pkg::*;
#(
   parameter int             IR_W      = 4,
   parameter logic [IR_W-1:0] OP_EXTEST = 'h0,
   parameter logic [IR_W-1:0] OP_SAMPLE = 'h2,
   parameter logic [IR_W-1:0] OP_RSTREG = 'hC,
   parameter logic [IR_W-1:0] OP_BYPASS = 'hF
) (
   input  logic     tck,
   input  logic     trst_n,
   input  logic     tdi,
   input  tap_st_e  st,
   output logic     ir_lsb,
   output dr_path_e path,
   output logic     extest
);

   localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] ir_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q <= '0;
         ir_q <= OP_BYPASS;
      end else begin
         case (st)
            TS_RESET:  ir_q <= OP_BYPASS;
            TS_CAP_IR: sh_q <= IR_CAPTURE;
            TS_SHF_IR: sh_q <= {tdi, sh_q[IR_W-1:1]};
            TS_UPD_IR: ir_q <= sh_q;
            default: ;
         endcase
      end
   end

   always_comb begin
      if (ir_q == OP_EXTEST || ir_q == OP_SAMPLE) path = PATH_BSC;
      else if (ir_q == OP_RSTREG)                 path = PATH_RST;
      else                                        path = PATH_BYP;
   end

   assign extest = (ir_q == OP_EXTEST);
   assign ir_lsb = sh_q[0];

endmodule

// File: rtl/jtp_bscan_chain.sv
module jtp_bscan_chain
   import jtp_pkg::*;
#(
   parameter int N_PINS = 4,
   localparam int CH_W  = N_PINS * CELLS_PER_PIN
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tdi,
   input  tap_st_e           st,
   input  logic              sel,
   input  logic              extest,
   input  logic [N_PINS-1:0] core_pud,
   input  logic [N_PINS-1:0] core_oe,
   input  logic [N_PINS-1:0] core_out,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_pud,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] core_in,
   output logic              sh_lsb,
   output logic [CH_W-1:0]   upd
);

   logic [CH_W-1:0] cap_v;
   logic [CH_W-1:0] sh_q;
   logic [CH_W-1:0] upd_q;

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      localparam int B = p * CELLS_PER_PIN;
      assign cap_v[B + CELL_PUD] = core_pud[p];
      assign cap_v[B + CELL_OE]  = core_oe[p];
      assign cap_v[B + CELL_OUT] = core_out[p];
      assign cap_v[B + CELL_IN]  = pad_in[p];

      assign pad_pud[p] = extest ? upd_q[B + CELL_PUD] : core_pud[p];
      assign pad_oe[p]  = extest ? upd_q[B + CELL_OE]  : core_oe[p];
      assign pad_out[p] = extest ? upd_q[B + CELL_OUT] : core_out[p];
      assign core_in[p] = extest ? upd_q[B + CELL_IN]  : pad_in[p];
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q  <= '0;
         upd_q <= '0;
      end else if (sel) begin
         case (st)
            TS_CAP_DR: sh_q  <= cap_v;
            TS_SHF_DR: sh_q  <= {tdi, sh_q[CH_W-1:1]};
            TS_UPD_DR: upd_q <= sh_q;
            default: ;
         endcase
      end
   end

   assign sh_lsb = sh_q[0];
   assign upd    = upd_q;

endmodule

// File: rtl/jtp_rst_timeout.sv
module jtp_rst_timeout
   import jtp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TMO_LEN0    = 16,
   parameter int TMO_LEN1    = 256,
   parameter int TMO_LEN2    = 4096,
   localparam int CNT_W      = $clog2(TMO_LEN2 + 1)
) (
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_st_e    st,
   input  logic       sel,
   input  logic       core_clk,
   input  logic [1:0] tmo_sel,
   output logic       rst_bit,
   output logic       tmo_busy,
   output logic       core_rst_req
);

   localparam logic [CNT_W-1:0] LEN0 = CNT_W'(TMO_LEN0);
   localparam logic [CNT_W-1:0] LEN1 = CNT_W'(TMO_LEN1);
   localparam logic [CNT_W-1:0] LEN2 = CNT_W'(TMO_LEN2);

   logic                   bit_q;
   logic [SYNC_STAGES-1:0] sy_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       len_v;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                      bit_q <= 1'b0;
      else if (st == TS_RESET)          bit_q <= 1'b0;
      else if (sel && st == TS_SHF_DR)  bit_q <= tdi;
   end

   always_ff @(posedge core_clk or negedge trst_n) begin
      if (!trst_n) sy_q <= '0;
      else         sy_q <= {sy_q[SYNC_STAGES-2:0], bit_q};
   end

   always_comb begin
      case (tmo_sel)
         2'd0:    len_v = LEN0;
         2'd1:    len_v = LEN1;
         default: len_v = LEN2;
      endcase
   end

   always_ff @(posedge core_clk or negedge trst_n) begin
      if (!trst_n)                 cnt_q <= '0;
      else if (sy_q[SYNC_STAGES-1]) cnt_q <= len_v;
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
   end

   assign rst_bit      = bit_q;
   assign tmo_busy     = (cnt_q != '0) || (|sy_q);
   assign core_rst_req = bit_q || tmo_busy;

endmodule

// File: rtl/jtag_rstscan_top.sv
module jtag_rstscan_top
   import jtp_pkg::*;
#(
   parameter int N_PINS      = 4,
   parameter int IR_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_LEN0    = 16,
   parameter int TMO_LEN1    = 256,
   parameter int TMO_LEN2    = 4096,
   parameter logic [IR_W-1:0] OP_EXTEST = 'h0,
   parameter logic [IR_W-1:0] OP_SAMPLE = 'h2,
   parameter logic [IR_W-1:0] OP_RSTREG = 'hC,
   parameter logic [IR_W-1:0] OP_BYPASS = 'hF
) (
   input  logic              tck,
   input  logic              tms,
   input  logic              tdi,
   input  logic              trst_n,
   output logic              tdo,
   output logic              tdo_en,
   input  logic              core_clk,
   input  logic [1:0]        tmo_sel,
   output logic              core_rst_req,
   input  logic [N_PINS-1:0] core_pud,
   input  logic [N_PINS-1:0] core_oe,
   input  logic [N_PINS-1:0] core_out,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_pud,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] core_in
);

   localparam int CH_W = N_PINS * CELLS_PER_PIN;

   if (N_PINS < 1) begin : g_bad_pins
      $error("N_PINS must be at least 1");
   end
   if (IR_W < 2) begin : g_bad_irw
      $error("IR_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TMO_LEN0 < 1 || TMO_LEN1 < TMO_LEN0 || TMO_LEN2 < TMO_LEN1) begin : g_bad_len
      $error("time-out lengths must be positive and non-decreasing");
   end
   if (OP_EXTEST == OP_SAMPLE || OP_EXTEST == OP_RSTREG || OP_SAMPLE == OP_RSTREG ||
       OP_BYPASS == OP_EXTEST || OP_BYPASS == OP_SAMPLE || OP_BYPASS == OP_RSTREG) begin : g_bad_op
      $error("opcodes must be distinct");
   end

   tap_st_e         st;
   dr_path_e        path;
   logic            extest;
   logic            ir_lsb;
   logic            bs_lsb;
   logic [CH_W-1:0] bs_upd;
   logic            rst_bit;
   logic            tmo_busy;
   logic            byp_q;
   logic            dr_lsb;
   logic            tdo_q;
   logic            tdo_en_q;

   jtp_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   jtp_instr_reg #(
      .IR_W      (IR_W),
      .OP_EXTEST (OP_EXTEST),
      .OP_SAMPLE (OP_SAMPLE),
      .OP_RSTREG (OP_RSTREG),
      .OP_BYPASS (OP_BYPASS)
   ) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .st     (st),
      .ir_lsb (ir_lsb),
      .path   (path),
      .extest (extest)
   );

   jtp_bscan_chain #(
      .N_PINS (N_PINS)
   ) u_bsc (
      .tck      (tck),
      .trst_n   (trst_n),
      .tdi      (tdi),
      .st       (st),
      .sel      (path == PATH_BSC),
      .extest   (extest),
      .core_pud (core_pud),
      .core_oe  (core_oe),
      .core_out (core_out),
      .pad_in   (pad_in),
      .pad_pud  (pad_pud),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out),
      .core_in  (core_in),
      .sh_lsb   (bs_lsb),
      .upd      (bs_upd)
   );

   jtp_rst_timeout #(
      .SYNC_STAGES (SYNC_STAGES),
      .TMO_LEN0    (TMO_LEN0),
      .TMO_LEN1    (TMO_LEN1),
      .TMO_LEN2    (TMO_LEN2)
   ) u_rst (
      .tck          (tck),
      .trst_n       (trst_n),
      .tdi          (tdi),
      .st           (st),
      .sel          (path == PATH_RST),
      .core_clk     (core_clk),
      .tmo_sel      (tmo_sel),
      .rst_bit      (rst_bit),
      .tmo_busy     (tmo_busy),
      .core_rst_req (core_rst_req)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (path == PATH_BYP) begin
         if (st == TS_CAP_DR)      byp_q <= 1'b0;
         else if (st == TS_SHF_DR) byp_q <= tdi;
      end
   end

   always_comb begin
      case (path)
         PATH_BSC: dr_lsb = bs_lsb;
         PATH_RST: dr_lsb = rst_bit;
         default:  dr_lsb = byp_q;
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
      end else if (st == TS_SHF_IR) begin
         tdo_q    <= ir_lsb;
         tdo_en_q <= 1'b1;
      end else if (st == TS_SHF_DR) begin
         tdo_q    <= dr_lsb;
         tdo_en_q <= 1'b1;
      end else begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_en = tdo_en_q;

endmodule

// File: rtl/jtp_checker.sv
module jtp_checker
   import jtp_pkg::*;
#(
   parameter int N_PINS = 4,
   localparam int CH_W  = N_PINS * CELLS_PER_PIN
) (
   input logic              tck,
   input logic              core_clk,
   input logic              trst_n,
   input logic              tms,
   input tap_st_e           st,
   input dr_path_e          path,
   input logic              extest,
   input logic              rst_bit,
   input logic              tmo_busy,
   input logic              core_rst_req,
   input logic [N_PINS-1:0] core_oe,
   input logic [N_PINS-1:0] pad_oe,
   input logic [CH_W-1:0]   bs_upd
);

   logic [2:0] ones_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            ones_q <= '0;
      else if (!tms)          ones_q <= '0;
      else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
   end

   assert_tlr_loads_bypass_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_RESET) |=> (path == PATH_BYP));

   assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_q == 3'd5) |-> (st == TS_RESET));

   assert_pads_follow_core_R5: assert property (@(posedge tck) disable iff (!trst_n)
      !extest |-> (pad_oe == core_oe));

   assert_upd_holds_R6: assert property (@(posedge tck) disable iff (!trst_n)
      (st != TS_UPD_DR) |=> $stable(bs_upd));

   assert_bit_forces_req_R7: assert property (@(posedge tck) disable iff (!trst_n)
      rst_bit |-> core_rst_req);

   assert_bit_moves_only_in_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (st != TS_SHF_DR && st != TS_RESET) |=> $stable(rst_bit));

   assert_busy_holds_req_R9: assert property (@(posedge core_clk) disable iff (!trst_n)
      tmo_busy |-> core_rst_req);

endmodule

bind jtag_rstscan_top jtp_checker #(.N_PINS(N_PINS)) u_chk (
   .tck          (tck),
   .core_clk     (core_clk),
   .trst_n       (trst_n),
   .tms          (tms),
   .st           (st),
   .path         (path),
   .extest       (extest),
   .rst_bit      (rst_bit),
   .tmo_busy     (tmo_busy),
   .core_rst_req (core_rst_req),
   .core_oe      (core_oe),
   .pad_oe       (pad_oe),
   .bs_upd       (bs_upd)
);

// File: tb/tb_jtag_rstscan_top.sv
`timescale 1ns/1ps
module tb_jtag_rstscan_top;

   localparam int NP = 4;
   localparam int CW = 16;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          trst_n, tms, tdi;
   logic [1:0]    tmo_sel;
   logic [NP-1:0] core_pud, core_oe, core_out, pad_in;
   logic          tdo, tdo_en, core_rst_req;
   logic [NP-1:0] pad_pud, pad_oe, pad_out, core_in;

   int   checks = 0;
   int   errs   = 0;
   logic tdo_s, req_s;

   jtag_rstscan_top dut (
      .tck(clk), .tms(tms), .tdi(tdi), .trst_n(trst_n),
      .tdo(tdo), .tdo_en(tdo_en),
      .core_clk(clk), .tmo_sel(tmo_sel), .core_rst_req(core_rst_req),
      .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .pad_in(pad_in),
      .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out), .core_in(core_in)
   );

   task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
      checks++;
      if (a !== e) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", r, a, e);
      end
   endtask

   task automatic step(input logic m, input logic d);
      @(negedge clk);
      #1;
      tdo_s = tdo;
      req_s = core_rst_req;
      tms   = m;
      tdi   = d;
   endtask

   task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, op[i]);
         cap[i] = tdo_s;
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         dout[i] = tdo_s;
      end
      step(1, 0); step(0, 0);
   endtask

   function automatic logic [CW-1:0] chain_of(input logic [NP-1:0] pu, oe, od, pi);
      logic [CW-1:0] v;
      for (int p = 0; p < NP; p++) begin
         v[4*p]   = pu[p];
         v[4*p+1] = oe[p];
         v[4*p+2] = od[p];
         v[4*p+3] = pi[p];
      end
      return v;
   endfunction

   task automatic tmo_run(input logic [1:0] sel, input int len);
      logic [63:0] dq;
      int j;
      tmo_sel = sel;
      dr_scan(1, 64'd1, dq);
      step(1, 0); step(0, 0); step(0, 0);
      step(1, 0);
      chk("R8 readback of set bit", 64'(tdo_s), 64'd1);
      j = 0;
      while (j < 10000) begin
         step(j == 0, 0);
         if (!req_s) break;
         j++;
      end
      chk($sformatf("R9 release delay sel=%0d", sel), 64'(j), 64'(len + SYNC));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired, run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      logic [3:0]  cap;
      logic [63:0] dq;
      logic [CW-1:0] pat;
      bit ok;
      trst_n = 0; tms = 1; tdi = 0; tmo_sel = 0;
      core_pud = 4'h3; core_oe = 4'h5; core_out = 4'h9; pad_in = 4'h6;
      repeat (3) @(posedge clk);
      #1 trst_n = 1;
      step(0, 0); step(0, 0);

      // R1 reset state
      chk("R1 tdo_en idle", 64'(tdo_en), 64'd0);
      chk("R1 core_rst_req", 64'(core_rst_req), 64'd0);
      chk("R1 pads follow core", 64'({pad_pud, pad_oe, pad_out}), 64'({core_pud, core_oe, core_out}));
      dr_scan(8, 64'hB5, dq);
      chk("R1 bypass after reset", dq[7:0], 64'h6A);

      // R3 instruction capture
      ir_scan(4'hF, cap);
      chk("R3 IR capture bits", 64'(cap), 64'd1);

      // R4 undefined opcodes all select bypass
      for (int op = 0; op < 16; op++) begin
         if (op == 0 || op == 2 || op == 12) continue;
         ir_scan(4'(op), cap);
         dr_scan(8, 64'hB5, dq);
         chk($sformatf("R4 bypass for opcode %0h", op), dq[7:0], 64'h6A);
      end

      // R5 sample sweep
      ir_scan(4'h2, cap);
      for (int v = 0; v < 16; v++) begin
         core_pud = 4'(v); core_oe = ~4'(v); core_out = 4'(v) ^ 4'h9; pad_in = 4'(v * 3 + 1);
         dr_scan(CW, 64'h0, dq);
         chk($sformatf("R5 sample capture v=%0d", v), dq[CW-1:0],
             64'(chain_of(core_pud, core_oe, core_out, pad_in)));
         chk("R5 pads follow core under sample",
             64'({pad_pud, pad_oe, pad_out, core_in}), 64'({core_pud, core_oe, core_out, pad_in}));
      end

      // R6 preload then external test
      for (int k = 0; k < 4; k++) begin
         pat = 16'hA5C3 ^ 16'(k * 16'h1357);
         ir_scan(4'h2, cap);
         dr_scan(CW, 64'(pat), dq);
         ir_scan(4'h0, cap);
         step(0, 0);
         for (int p = 0; p < NP; p++) begin
            chk("R6 pad pull-up disable", 64'(pad_pud[p]), 64'(pat[4*p]));
            chk("R6 pad output enable",   64'(pad_oe[p]),  64'(pat[4*p+1]));
            chk("R6 pad output data",     64'(pad_out[p]), 64'(pat[4*p+2]));
            chk("R6 core input cell",     64'(core_in[p]), 64'(pat[4*p+3]));
         end
         core_oe = ~core_oe; core_out = ~core_out;
         step(0, 0);
         chk("R6 core change ignored", 64'({pad_oe, pad_out}),
             64'({pat[13], pat[9], pat[5], pat[1], pat[14], pat[10], pat[6], pat[2]}));
      end

      // R2 five TMS-high cycles leave external test
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0); step(0, 0);
      chk("R2 pads back to core after TLR", 64'({pad_oe, pad_out}), 64'({core_oe, core_out}));
      dr_scan(8, 64'hB5, dq);
      chk("R2 bypass after TLR", dq[7:0], 64'h6A);

      // R7/R8 reset register
      ir_scan(4'hC, cap);
      step(1, 0); step(0, 0); step(0, 0);
      step(1, 1);
      chk("R7 req low before shift edge", 64'(req_s), 64'd0);
      chk("R8 current bit 0 shifted out first", 64'(tdo_s), 64'd0);
      step(1, 0);
      chk("R7 req high right after shift edge", 64'(req_s), 64'd1);
      step(0, 0);
      ok = 1;
      for (int i = 0; i < 20; i++) begin
         step(0, 0);
         if (!req_s) ok = 0;
      end
      chk("R7 req held while bit set", 64'(ok), 64'd1);

      // R9 time-out lengths
      tmo_run(2'd0, 16);
      tmo_run(2'd1, 256);
      tmo_run(2'd2, 4096);
      tmo_run(2'd3, 4096);

      // R10 restart before expiry
      tmo_sel = 2'd0;
      dr_scan(1, 64'd1, dq);
      dr_scan(1, 64'd0, dq);
      step(0, 0); step(0, 0);
      chk("R10 still timing out", 64'(req_s), 64'd1);
      tmo_run(2'd0, 16);
      chk("R10 restarted count left request low", 64'(core_rst_req), 64'd0);

      // R1 trst clears the reset bit and counter
      dr_scan(1, 64'd1, dq);
      step(0, 0);
      trst_n = 0;
      #1;
      chk("R1 trst drops req", 64'(core_rst_req), 64'd0);
      chk("R1 trst drops tdo_en", 64'(tdo_en), 64'd0);
      #1 trst_n = 1;
      step(0, 0); step(0, 0);
      dr_scan(8, 64'hB5, dq);
      chk("R1 bypass after trst", dq[7:0], 64'h6A);
      chk("R1 req stays low after trst", 64'(core_rst_req), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule